// File: doc/BRIEF.md
# Core Voltage Reference Sequencer

This block produces the digital regulation target for a multiphase core-voltage regulator. It turns a 7-bit voltage code from the processor into a level and runs the power-up order. After the enable input rises, it waits a soft-start delay. It then ramps one level at a time from 50 mV to a fixed boot voltage, holds there for a boot delay, and only then pulls the active-low clock-enable output low. From that point on, the target follows the requested code.

The target never jumps. Every move is one step of 12.5 mV, spaced by a microsecond tick. The spacing depends on the kind of move. A move of exactly one step is taken on the next tick. A longer move goes slowly while the deeper-sleep input is high and four times faster while it is low. The spacing comes from a fractional accumulator that advances on each tick. A busy flag tells power-good logic that the target is still moving. Dropping enable abandons everything at once.

The target is reported in half-millivolt units so that a 987.5 mV boot level can be expressed exactly. Delay lengths, the boot level and the slew increments are parameters.

Top module: `vid_ref_sequencer`

## Requirements
- R1: Code c maps to 1500 − 12.5·c mV, clamped at a minimum of 300 mV. `target_hmv` reports the target as twice its millivolt value: code 0 gives 3000, and codes 96 through 127 give 600. While clock-enable is low, the target stays within 600..3000.
- R2: Out of reset, and whenever `en` is low, `target_hmv` is 0, `clken_n` is 1 and `busy` is 0.
- R3: After `en` rises, the target stays 0 through 199 ticks and becomes 100 (50 mV) on the 200th tick.
- R4: During soft-start, the target rises by 25 (one step) every 16 ticks until it reaches the boot level of 2200 (1100 mV), on tick 200 + 84·16 = 1544.
- R5: `clken_n` falls on the 60th tick after the boot level is reached (tick 1604), with the target at the boot level. It stays low while `en` stays high.
- R6: With `dprslp` high, a move of two or more steps takes one step per 16 ticks.
- R7: With `dprslp` low, a move of two or more steps takes one step per 4 ticks.
- R8: A move of exactly one step is taken on the first tick after the new code is latched.
- R9: `busy` is high from the enable edge until clock-enable falls. After that it is high whenever the target differs from the level of the current code. Once the target settles it is low and the target equals that level.
- R10: Dropping `en` at any point clears the target and raises `clken_n` on the next clock. Raising `en` again restarts the whole sequence from the delay.
- R11: With `en` held high, the target changes only on a clock edge that samples `tick_us` high. Each change is one step (25), except the first jump from 0 to 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| en | input | 1 | Regulator enable; low aborts and clears |
| dprslp | input | 1 | Deeper-sleep state; high selects the slow slew |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| vid | input | 7 | Requested voltage code |
| target_hmv | output | 12 | Regulation target in 0.5 mV units |
| clken_n | output | 1 | Active-low clock enable |
| busy | output | 1 | Target is moving or the sequence is not finished |

## Verification
The assertions assume that `tick_us` is a single-cycle pulse with at least one idle cycle between pulses. They also assume that `vid` and `dprslp` change only between clock edges. The bench generates the tick on every other clock. It raises enable and changes the code only on a cycle whose next edge sees no tick, so each new code is latched with a clean accumulator. The bench waits for each move to settle before it requests the next, except in the one case where enable is dropped in the middle of a slew on purpose.

// File: rtl/vref_pkg.sv
package vref_pkg;
  localparam int VID_W       = 7;
  localparam int LVL_W       = 7;
  localparam int LVL_MAX     = 120;  // 1500 mV in 12.5 mV steps
  localparam int LVL_MIN     = 24;   // 300 mV floor
  localparam int HMV_PER_LVL = 25;   // 12.5 mV in half-millivolts
  localparam int HMV_W       = 12;

  typedef enum logic [2:0] {
    ST_OFF, ST_DELAY, ST_RAMP, ST_HOLD, ST_TRACK
  } seq_state_e;

  function automatic logic [LVL_W-1:0] vid_to_lvl(input logic [VID_W-1:0] code);
    int c;
    c = int'(code);
    if (c >= LVL_MAX - LVL_MIN) return LVL_W'(LVL_MIN);
    return LVL_W'(LVL_MAX - c);
  endfunction

  function automatic logic [HMV_W-1:0] lvl_to_hmv(input logic [LVL_W-1:0] lvl);
    return HMV_W'(int'(lvl) * HMV_PER_LVL);
  endfunction

  function automatic logic lvl_adjacent(input logic [LVL_W-1:0] a,
                                        input logic [LVL_W-1:0] b);
    return (a == b + LVL_W'(1)) || (b == a + LVL_W'(1));
  endfunction
endpackage

// File: rtl/vref_seq_fsm.sv
module vref_seq_fsm
  import vref_pkg::*;
#(
  parameter int DELAY_US   = 200,
  parameter int STEP_US    = 16,
  parameter int RAMP_STEPS = 84,
  parameter int HOLD_US    = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  output seq_state_e state,
  output logic       load_start,
  output logic       ramp_step,
  output logic       enter_track
);
  localparam int TMR_W = $clog2(DELAY_US + STEP_US + HOLD_US + 1);
  localparam int CNT_W = $clog2(RAMP_STEPS + 1);

  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] nsteps;
  logic             delay_end, step_end, hold_end, last_step;

  assign delay_end = en && tick && (state == ST_DELAY) && (tmr == TMR_W'(DELAY_US - 1));
  assign step_end  = en && tick && (state == ST_RAMP)  && (tmr == TMR_W'(STEP_US - 1));
  assign hold_end  = en && tick && (state == ST_HOLD)  && (tmr == TMR_W'(HOLD_US - 1));
  assign last_step = (nsteps == CNT_W'(RAMP_STEPS - 1));

  assign load_start  = delay_end;
  assign ramp_step   = step_end;
  assign enter_track = hold_end;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      state  <= ST_OFF;
      tmr    <= '0;
      nsteps <= '0;
    end else begin
      unique case (state)
        ST_OFF: begin
          state <= ST_DELAY;
          tmr   <= '0;
        end
        ST_DELAY: begin
          if (delay_end) begin
            state  <= ST_RAMP;
            tmr    <= '0;
            nsteps <= '0;
          end else if (tick) begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_RAMP: begin
          if (step_end) begin
            tmr    <= '0;
            nsteps <= nsteps + CNT_W'(1);
            if (last_step) state <= ST_HOLD;
          end else if (tick) begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        ST_HOLD: begin
          if (hold_end) begin
            state <= ST_TRACK;
            tmr   <= '0;
          end else if (tick) begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: state <= ST_TRACK;
      endcase
    end
  end
endmodule

// File: rtl/vref_slew_unit.sv
module vref_slew_unit
  import vref_pkg::*;
#(
  parameter int FRAC_W    = 4,
  parameter int SLOW_INC  = 1,
  parameter int FAST_INC  = 4,
  parameter int START_LVL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             dprslp,
  input  logic             load_start,
  input  logic             ramp_step,
  input  logic             track_en,
  input  logic             enter_track,
  input  logic [LVL_W-1:0] vid_lvl,
  output logic [LVL_W-1:0] lvl,
  output logic [LVL_W-1:0] req_lvl,
  output logic             step_evt
);
  localparam int INC_W   = FRAC_W + 1;
  localparam int ONE_INC = 1 << FRAC_W;

  logic [FRAC_W-1:0] acc;
  logic [INC_W-1:0]  inc, sum;
  logic              single_q, new_req, moving;

  assign new_req  = enter_track || (track_en && (vid_lvl != req_lvl));
  assign inc      = single_q ? INC_W'(ONE_INC) : (dprslp ? INC_W'(SLOW_INC) : INC_W'(FAST_INC));
  assign sum      = {1'b0, acc} + inc;
  assign moving   = track_en && !new_req && tick && (lvl != req_lvl);
  assign step_evt = moving && sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      lvl      <= '0;
      req_lvl  <= '0;
      acc      <= '0;
      single_q <= 1'b0;
    end else if (load_start) begin
      lvl <= LVL_W'(START_LVL);
    end else if (ramp_step) begin
      lvl <= lvl + LVL_W'(1);
    end else if (new_req) begin
      req_lvl  <= vid_lvl;
      single_q <= lvl_adjacent(vid_lvl, lvl);
      acc      <= '0;
    end else if (moving) begin
      acc <= sum[FRAC_W-1:0];
      if (step_evt) lvl <= (lvl < req_lvl) ? lvl + LVL_W'(1) : lvl - LVL_W'(1);
    end
  end
endmodule

// File: rtl/vid_ref_sequencer.sv
module vid_ref_sequencer
  import vref_pkg::*;
#(
  parameter int SS_DELAY_US  = 200,
  parameter int SS_RAMP_US   = 1400,
  parameter int BOOT_HOLD_US = 60,
  parameter int BOOT_LVL     = 88,   // 79 selects the 987.5 mV variant
  parameter int SS_START_LVL = 4,
  parameter int FRAC_W       = 4,
  parameter int SLOW_INC     = 1,
  parameter int FAST_INC     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dprslp,
  input  logic             tick_us,
  input  logic [VID_W-1:0] vid,
  output logic [HMV_W-1:0] target_hmv,
  output logic             clken_n,
  output logic             busy
);
  localparam int RAMP_STEPS = BOOT_LVL - SS_START_LVL;
  localparam int STEP_US    = SS_RAMP_US / RAMP_STEPS;

  seq_state_e       state;
  logic             load_start, ramp_step, enter_track, step_evt;
  logic [LVL_W-1:0] vid_lvl, lvl, req_lvl;
  logic             track_en;

  assign vid_lvl  = vid_to_lvl(vid);
  assign track_en = (state == ST_TRACK);

  vref_seq_fsm #(
    .DELAY_US  (SS_DELAY_US),
    .STEP_US   (STEP_US),
    .RAMP_STEPS(RAMP_STEPS),
    .HOLD_US   (BOOT_HOLD_US)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (tick_us),
    .state      (state),
    .load_start (load_start),
    .ramp_step  (ramp_step),
    .enter_track(enter_track)
  );

  vref_slew_unit #(
    .FRAC_W   (FRAC_W),
    .SLOW_INC (SLOW_INC),
    .FAST_INC (FAST_INC),
    .START_LVL(SS_START_LVL)
  ) u_slew (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (tick_us),
    .dprslp     (dprslp),
    .load_start (load_start),
    .ramp_step  (ramp_step),
    .track_en   (track_en),
    .enter_track(enter_track),
    .vid_lvl    (vid_lvl),
    .lvl        (lvl),
    .req_lvl    (req_lvl),
    .step_evt   (step_evt)
  );

  assign target_hmv = lvl_to_hmv(lvl);
  assign clken_n    = !track_en;

  always_comb begin
    unique case (state)
      ST_OFF:   busy = 1'b0;
      ST_TRACK: busy = (lvl != req_lvl) || (req_lvl != vid_lvl);
      default:  busy = 1'b1;
    endcase
  end
endmodule

// File: rtl/vref_seq_checker.sv
module vref_seq_checker
  import vref_pkg::*;
#(
  parameter int BOOT_LVL = 88
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick_us,
  input logic [VID_W-1:0] vid,
  input logic [HMV_W-1:0] target_hmv,
  input logic             clken_n,
  input logic             busy
);
  localparam int BOOT_HMV = BOOT_LVL * HMV_PER_LVL;

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (target_hmv == '0 && clken_n && !busy)); // R10

  AST_CLKEN_AT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clken_n) |-> (int'(target_hmv) == BOOT_HMV)); // R5

  AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && target_hmv != $past(target_hmv)) |-> $past(tick_us)); // R11

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(target_hmv) != '0 && target_hmv != $past(target_hmv))
    |-> (int'(target_hmv) - int'($past(target_hmv)) == HMV_PER_LVL ||
         int'($past(target_hmv)) - int'(target_hmv) == HMV_PER_LVL)); // R4

  AST_FIRST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(target_hmv) == '0 && target_hmv != '0)
    |-> (target_hmv == HMV_W'(100))); // R3

  AST_TRACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clken_n |-> (int'(target_hmv) >= LVL_MIN * HMV_PER_LVL &&
                  int'(target_hmv) <= LVL_MAX * HMV_PER_LVL)); // R1

  AST_SETTLED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && !busy) |-> (target_hmv == lvl_to_hmv(vid_to_lvl(vid)))); // R9
endmodule

bind vid_ref_sequencer vref_seq_checker #(.BOOT_LVL(BOOT_LVL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .tick_us   (tick_us),
  .vid       (vid),
  .target_hmv(target_hmv),
  .clken_n   (clken_n),
  .busy      (busy)
);

// File: tb/tb_vid_ref_sequencer.sv
module tb_vid_ref_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int DELAY_T = 200;
  localparam int STEP_T  = 16;
  localparam int HOLD_T  = 60;
  localparam int BOOT_L  = 88;
  localparam int START_L = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       dprslp = 1'b0;
  logic       tick_us = 1'b0;
  logic [6:0] vid = 7'd0;
  logic [11:0] target_hmv;
  logic       clken_n, busy;

  int nchk = 0, nfail = 0, tcount = 0, cur = 0, prev = 0;
  bit done = 1'b0;
  int    qv[$];
  int    qt[$];
  string qg[$];

  vid_ref_sequencer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dprslp(dprslp), .tick_us(tick_us),
    .vid(vid), .target_hmv(target_hmv), .clken_n(clken_n), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tick_us <= 1'b0;
    else        tick_us <= ~tick_us;
  end

  always @(posedge clk) begin
    if (!en)          tcount <= 0;
    else if (tick_us) tcount <= tcount + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_hmv(input int code);
    int v;
    v = 3000 - 25 * code;
    return (v < 600) ? 600 : v;
  endfunction

  task automatic push(input int v, input int t, input string g);
    qv.push_back(v); qt.push_back(t); qg.push_back(g);
  endtask

  // monitor: compare every change of the target with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && int'(target_hmv) != prev) begin
      if (qv.size() == 0) begin
        chk(1'b0, "R11 unexpected change", int'(target_hmv), prev);
      end else begin
        int v, t;
        string g;
        v = qv.pop_front(); t = qt.pop_front(); g = qg.pop_front();
        chk(int'(target_hmv) == v, {g, " level"}, int'(target_hmv), v);
        if (t >= 0) chk(tcount == t, {g, " tick"}, tcount, t);
      end
      prev = int'(target_hmv);
    end
  end

  task automatic push_slew(input int from, input int to, input int period,
                           input int base, input string g);
    int n, dir;
    dir = (to > from) ? 25 : -25;
    n = (to > from) ? (to - from) / 25 : (from - to) / 25;
    for (int k = 1; k <= n; k++) push(from + dir * k, base + k * period, g);
  endtask

  function automatic int period_of(input int from, input int to);
    int d;
    d = (to > from) ? to - from : from - to;
    if (d == 25) return 1;
    return dprslp ? 16 : 4;
  endfunction

  function automatic string tag_of(input int from, input int to);
    int d;
    d = (to > from) ? to - from : from - to;
    if (d == 25) return "R8";
    return dprslp ? "R6" : "R7";
  endfunction

  task automatic align();
    @(negedge clk);
    while (tick_us) @(negedge clk);
    #1;
  endtask

  task automatic wait_tick(input int n);
    do @(negedge clk); while (tcount != n);
  endtask

  task automatic wait_drain();
    while (qv.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_startup(input int code);
    int to;
    vid = 7'(code);
    for (int l = START_L; l <= BOOT_L; l++)
      push(l * 25, DELAY_T + (l - START_L) * STEP_T, (l == START_L) ? "R3" : "R4");
    to = exp_hmv(code);
    push_slew(BOOT_L * 25, to, period_of(BOOT_L * 25, to),
              DELAY_T + (BOOT_L - START_L) * STEP_T + HOLD_T, tag_of(BOOT_L * 25, to));
    align();
    en = 1'b1;
    wait_tick(DELAY_T - 1);
    chk(target_hmv == 12'd0, "R3 held in delay", int'(target_hmv), 0);
    chk(busy == 1'b1, "R9 busy in delay", int'(busy), 1);
    wait_tick(DELAY_T + (BOOT_L - START_L) * STEP_T + HOLD_T - 1);
    chk(clken_n == 1'b1, "R5 clken before hold end", int'(clken_n), 1);
    wait_tick(DELAY_T + (BOOT_L - START_L) * STEP_T + HOLD_T);
    chk(clken_n == 1'b0, "R5 clken at hold end", int'(clken_n), 0);
    cur = to;
    wait_drain();
    chk(busy == 1'b0, "R9 settled after boot", int'(busy), 0);
  endtask

  task automatic request(input int code, input bit settle);
    int to, base;
    align();
    base = tcount;
    to = exp_hmv(code);
    vid = 7'(code);
    push_slew(cur, to, period_of(cur, to), base, tag_of(cur, to));
    cur = to;
    @(negedge clk);
    chk(busy == 1'b1, "R9 busy while moving", int'(busy), 1);
    if (settle) begin
      wait_drain();
      chk(busy == 1'b0, "R9 settled", int'(busy), 0);
      chk(int'(target_hmv) == to, "R1 final level", int'(target_hmv), to);
    end
  endtask

  task automatic disable_now();
    align();
    qv.delete(); qt.delete(); qg.delete();
    push(0, -1, "R10");
    en = 1'b0;
    @(negedge clk);
    chk(clken_n == 1'b1, "R10 clken released", int'(clken_n), 1);
    chk(busy == 1'b0, "R2 busy cleared", int'(busy), 0);
    cur = 0;
    wait_drain();
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(target_hmv == 12'd0, "R2 reset target", int'(target_hmv), 0);
    chk(clken_n == 1'b1, "R2 reset clken", int'(clken_n), 1);
    chk(busy == 1'b0, "R2 reset busy", int'(busy), 0);

    dprslp = 1'b0;
    run_startup(40);              // 2200 -> 2000, fast
    dprslp = 1'b1;
    request(36, 1'b1);            // up 4 steps slow (R6)
    request(37, 1'b1);            // single step (R8)
    dprslp = 1'b0;
    request(127, 1'b1);           // clamp to 600 (R1, R7)
    request(0, 1'b1);             // top code 3000 (R1)
    dprslp = 1'b1;
    request(2, 1'b1);             // 2 steps slow (R6)
    dprslp = 1'b0;
    request(60, 1'b0);            // long move, aborted midway
    repeat (100) @(negedge clk);
    disable_now();                // R10

    dprslp = 1'b1;
    run_startup(50);              // full restart (R10), slow to 1750
    disable_now();
    chk(qv.size() == 0, "R11 scoreboard drained", qv.size(), 0);
    report();
  end
endmodule